// File: doc/BRIEF.md
# Ethernet PHY Interrupt Status and Enable Register

This block is one 16-bit register in the management space of an Ethernet PHY. It collects eight events from the link, receive and auto-negotiation logic. Each event sets a sticky status bit in the low byte. The high byte holds one enable per status bit. When any status bit is set and its enable is also set, the block drives an interrupt pin. A separate polarity input chooses whether that pin is active high or active low.

Software reaches the register through a simple parallel port with an address, a read strobe, a write strobe and write data. A read returns the full 16-bit value and clears the status byte at the same clock edge, so the same register also works for polling with every enable at 0. Two status bits are set by edges that the block detects itself: a rising edge on the receive-error level, and a drop of the link-OK level. The other six inputs set their bit in every cycle they are high.

Top module: `phy_irq_reg`

## Requirements
- R1: After reset all 16 register bits are 0. The interrupt pin is at its inactive level (0 when `irq_active_high`=1, 1 when it is 0).
- R2: Status bit positions are: 7 jabber, 6 receive error, 5 page received, 4 parallel-detect fault, 3 link-partner acknowledge, 2 link went down, 1 remote fault, 0 auto-negotiation complete. A set bit stays set until a clearing read.
- R3: When `reg_rd`=1 and `reg_addr`=17, `reg_rdata` shows {enables[15:8], status[7:0]} in that cycle, and status bits 7..0 clear at the clock edge. A read at any other address returns 0 and clears nothing. With `reg_rd`=0, `reg_rdata` is 0.
- R4: An event in the same cycle as a clearing read leaves its status bit set after that edge.
- R5: Status bit 6 sets only on a 0-to-1 transition of `rx_err_lvl`. Holding the input high sets it once.
- R6: Status bit 2 sets only when `link_ok_lvl` goes from 1 (OK) to 0 (FAIL). A 0-to-1 transition sets nothing.
- R7: The interrupt is active when (status & enables) is non-zero, at the level chosen by `irq_active_high`. It is registered: it becomes active in the cycle after the event edge and becomes inactive in the cycle after a clearing read when no new event is pending.
- R8: With all enables at 0, events still latch into status and can be read, and the interrupt pin stays inactive.
- R9: A write with `reg_wr`=1 and `reg_addr`=17 loads bits 15..8 only. Bits 7..0 of the write data are ignored. Writes to other addresses change nothing.
- R10: The edge history resets to the idle levels (receive error low, link FAIL). A reset with idle inputs, followed by the link coming up, sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 5 | Management register address |
| reg_rd | input | 1 | Read strobe, one cycle per read |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data (only 15..8 used) |
| reg_rdata | output | 16 | Read data |
| ev_jabber | input | 1 | Jabber event |
| rx_err_lvl | input | 1 | Receive-error level, edge detected |
| ev_page_rx | input | 1 | Page received event |
| ev_pd_fault | input | 1 | Parallel-detect fault event |
| ev_lp_ack | input | 1 | Link-partner acknowledge event |
| link_ok_lvl | input | 1 | Link status level, 1 = OK |
| ev_rem_fault | input | 1 | Remote fault event |
| ev_an_done | input | 1 | Auto-negotiation complete event |
| irq_active_high | input | 1 | Interrupt polarity, 1 = active high |
| irq_pin | output | 1 | Interrupt output |

## Verification
The assertions check these rules in every cycle:
- A status bit stays set unless a clearing read occurs.
- After a clearing read, status holds exactly the events of that cycle.
- Bit 6 and bit 2 rise only after their own edge condition.
- The interrupt pin always equals the masked OR of status and enables, at the selected level.
- The enables move only on an addressed write.

The bench scenarios show the rest:
- The bit order.
- That a held receive error sets its bit once.
- That a link coming up or a reset with idle inputs leaves status clear.
- That reads at other addresses neither return data nor clear.
- The exact cycle in which the interrupt rises and falls.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;

  // Status bit positions inside the event byte
  localparam int unsigned BIT_AN_DONE   = 0;
  localparam int unsigned BIT_REM_FAULT = 1;
  localparam int unsigned BIT_LINK_DOWN = 2;
  localparam int unsigned BIT_LP_ACK    = 3;
  localparam int unsigned BIT_PD_FAULT  = 4;
  localparam int unsigned BIT_PAGE_RX   = 5;
  localparam int unsigned BIT_RX_ERR    = 6;
  localparam int unsigned BIT_JABBER    = 7;
  localparam int unsigned NUM_EVENTS    = 8;

  typedef logic [NUM_EVENTS-1:0] ev_vec_t;

  // Sticky update: clear on read, but an event in the same cycle wins
  function automatic ev_vec_t f_sticky_next(input ev_vec_t cur,
                                            input ev_vec_t set,
                                            input logic    clr);
    ev_vec_t kept;
    kept = clr ? '0 : cur;
    return kept | set;
  endfunction

  // Any enabled status bit pending
  function automatic logic f_masked_any(input ev_vec_t stat,
                                        input ev_vec_t ena);
    return |(stat & ena);
  endfunction

endpackage

// File: rtl/phy_irq_edge.sv
module phy_irq_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_err_lvl,
  input  logic link_ok_lvl,
  output logic rx_err_q,
  output logic link_ok_q,
  output logic rx_err_rise,
  output logic link_drop
);

  // History resets to idle: receive error low, link FAIL
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_err_q  <= 1'b0;
      link_ok_q <= 1'b0;
    end else begin
      rx_err_q  <= rx_err_lvl;
      link_ok_q <= link_ok_lvl;
    end
  end

  assign rx_err_rise = rx_err_lvl & ~rx_err_q;
  assign link_drop   = ~link_ok_lvl & link_ok_q;

endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status
  import phy_irq_pkg::*;
#(
  parameter int unsigned N_EV = NUM_EVENTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] set_vec,
  input  logic            rd_clr,
  output logic [N_EV-1:0] status,
  output logic [N_EV-1:0] status_nxt
);

  always_comb status_nxt = f_sticky_next(status, set_vec, rd_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_nxt;
  end

endmodule

// File: rtl/phy_irq_enable.sv
module phy_irq_enable #(
  parameter int unsigned N_EV = 8,
  localparam int unsigned DW  = 2 * N_EV
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_hit,
  input  logic [DW-1:0]   wdata,
  output logic [N_EV-1:0] enable,
  output logic [N_EV-1:0] enable_nxt
);

  // Only the upper half of the write word is stored
  always_comb enable_nxt = wr_hit ? wdata[DW-1:N_EV] : enable;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enable <= '0;
    else        enable <= enable_nxt;
  end

endmodule

// File: rtl/phy_irq_drive.sv
module phy_irq_drive
  import phy_irq_pkg::*;
#(
  parameter int unsigned N_EV = NUM_EVENTS
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] status_nxt,
  input  logic [N_EV-1:0] enable_nxt,
  input  logic            active_high,
  output logic            irq_req,
  output logic            irq_pin
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_req <= 1'b0;
    else        irq_req <= f_masked_any(status_nxt, enable_nxt);
  end

  assign irq_pin = active_high ? irq_req : ~irq_req;

endmodule

// File: rtl/phy_irq_reg.sv
module phy_irq_reg
  import phy_irq_pkg::*;
#(
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned REG_ADDR = 17,
  parameter int unsigned N_EV     = NUM_EVENTS,
  localparam int unsigned DW      = 2 * N_EV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              ev_jabber,
  input  logic              rx_err_lvl,
  input  logic              ev_page_rx,
  input  logic              ev_pd_fault,
  input  logic              ev_lp_ack,
  input  logic              link_ok_lvl,
  input  logic              ev_rem_fault,
  input  logic              ev_an_done,
  input  logic              irq_active_high,
  output logic              irq_pin
);

  // Named internal events, visible to the bound checker
  logic            addr_hit;
  logic            rd_clr;
  logic            wr_hit;
  logic            rx_err_q;
  logic            link_ok_q;
  logic            rx_err_rise;
  logic            link_drop;
  logic            irq_req;
  logic [N_EV-1:0] set_vec;
  logic [N_EV-1:0] status;
  logic [N_EV-1:0] status_nxt;
  logic [N_EV-1:0] enable;
  logic [N_EV-1:0] enable_nxt;

  assign addr_hit = (reg_addr == ADDR_W'(REG_ADDR));
  assign rd_clr   = reg_rd & addr_hit;
  assign wr_hit   = reg_wr & addr_hit;

  phy_irq_edge i_edge (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_err_lvl  (rx_err_lvl),
    .link_ok_lvl (link_ok_lvl),
    .rx_err_q    (rx_err_q),
    .link_ok_q   (link_ok_q),
    .rx_err_rise (rx_err_rise),
    .link_drop   (link_drop)
  );

  always_comb begin
    set_vec                = '0;
    set_vec[BIT_JABBER]    = ev_jabber;
    set_vec[BIT_RX_ERR]    = rx_err_rise;
    set_vec[BIT_PAGE_RX]   = ev_page_rx;
    set_vec[BIT_PD_FAULT]  = ev_pd_fault;
    set_vec[BIT_LP_ACK]    = ev_lp_ack;
    set_vec[BIT_LINK_DOWN] = link_drop;
    set_vec[BIT_REM_FAULT] = ev_rem_fault;
    set_vec[BIT_AN_DONE]   = ev_an_done;
  end

  phy_irq_status #(.N_EV(N_EV)) i_status (
    .clk        (clk),
    .rst_n      (rst_n),
    .set_vec    (set_vec),
    .rd_clr     (rd_clr),
    .status     (status),
    .status_nxt (status_nxt)
  );

  phy_irq_enable #(.N_EV(N_EV)) i_enable (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_hit     (wr_hit),
    .wdata      (reg_wdata),
    .enable     (enable),
    .enable_nxt (enable_nxt)
  );

  phy_irq_drive #(.N_EV(N_EV)) i_drive (
    .clk         (clk),
    .rst_n       (rst_n),
    .status_nxt  (status_nxt),
    .enable_nxt  (enable_nxt),
    .active_high (irq_active_high),
    .irq_req     (irq_req),
    .irq_pin     (irq_pin)
  );

  // Read data is the pre-clear value during the read cycle
  assign reg_rdata = rd_clr ? {enable, status} : '0;

endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int unsigned N_EV = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_clr,
  input logic            wr_hit,
  input logic            rx_err_lvl,
  input logic            rx_err_q,
  input logic            link_ok_lvl,
  input logic            link_ok_q,
  input logic            irq_active_high,
  input logic            irq_pin,
  input logic [N_EV-1:0] set_vec,
  input logic [N_EV-1:0] status,
  input logic [N_EV-1:0] enable
);

  p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((status & $past(status)) == $past(status)));

  // R4 is covered too: the events of the read cycle survive
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (status == $past(set_vec)));

  p_rxerr_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[6]) |-> $past(rx_err_lvl && !rx_err_q));

  p_link_drop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[2]) |-> $past(!link_ok_lvl && link_ok_q));

  p_irq_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin == (irq_active_high ? (|(status & enable)) : !(|(status & enable))));

  p_enable_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hit |=> $stable(enable));

endmodule

bind phy_irq_reg phy_irq_chk #(.N_EV(N_EV)) i_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .rd_clr          (rd_clr),
  .wr_hit          (wr_hit),
  .rx_err_lvl      (rx_err_lvl),
  .rx_err_q        (rx_err_q),
  .link_ok_lvl     (link_ok_lvl),
  .link_ok_q       (link_ok_q),
  .irq_active_high (irq_active_high),
  .irq_pin         (irq_pin),
  .set_vec         (set_vec),
  .status          (status),
  .enable          (enable)
);

// File: tb/test_phy_irq_reg.sv
`timescale 1ns/1ps
module test_phy_irq_reg;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [7:0]  ev_in = '0;
  logic        pol = 1'b1;
  logic        irq_pin;

  int unsigned n_vec  = 0;
  int unsigned n_fail = 0;
  bit          done = 1'b0;

  logic [7:0]  m_stat = '0;
  logic [7:0]  m_en   = '0;
  logic        m_rx   = 1'b0;
  logic        m_link = 1'b0;
  logic [15:0] last_rd = '0;

  always #2 clk = ~clk;

  phy_irq_reg i_phy_irq_reg (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_rd          (reg_rd),
    .reg_wr          (reg_wr),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .ev_jabber       (ev_in[7]),
    .rx_err_lvl      (ev_in[6]),
    .ev_page_rx      (ev_in[5]),
    .ev_pd_fault     (ev_in[4]),
    .ev_lp_ack       (ev_in[3]),
    .link_ok_lvl     (ev_in[2]),
    .ev_rem_fault    (ev_in[1]),
    .ev_an_done      (ev_in[0]),
    .irq_active_high (pol),
    .irq_pin         (irq_pin)
  );

  // Events seen at an edge: bit 6 on a rise, bit 2 on a drop
  function automatic logic [7:0] exp_set(input logic [7:0] ev, input logic prx, input logic plink);
    logic [7:0] s;
    s    = ev;
    s[6] = ev[6] && !prx;
    s[2] = !ev[2] && plink;
    return s;
  endfunction

  function automatic logic exp_pin(input logic [7:0] st, input logic [7:0] en, input logic p);
    logic any;
    any = (st & en) != 8'h00;
    return p ? any : !any;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, check read data, advance model, check pin
  task automatic step(input logic rd, input logic wr, input logic [4:0] a,
                      input logic [15:0] wd, input logic [7:0] ev);
    logic        hit;
    logic [7:0]  s;
    logic [15:0] exp_rd;
    reg_rd = rd; reg_wr = wr; reg_addr = a; reg_wdata = wd; ev_in = ev;
    #1;
    hit    = (a == 5'd17);
    exp_rd = (rd && hit) ? {m_en, m_stat} : 16'h0000;
    last_rd = reg_rdata;
    if (rd) chk("R3 read data", reg_rdata, exp_rd);
    s = exp_set(ev, m_rx, m_link);
    @(posedge clk);
    m_stat = ((rd && hit) ? 8'h00 : m_stat) | s;
    if (wr && hit) m_en = wd[15:8];
    m_rx   = ev[6];
    m_link = ev[2];
    @(negedge clk);
    chk("R7 irq pin", {15'b0, irq_pin}, {15'b0, exp_pin(m_stat, m_en, pol)});
  endtask

  task automatic do_reset();
    rst_n = 1'b0; reg_rd = 0; reg_wr = 0; ev_in = '0;
    repeat (3) @(negedge clk);
    m_stat = '0; m_en = '0; m_rx = 0; m_link = 0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    do_reset();

    // R1 reset state
    chk("R1 pin after reset", {15'b0, irq_pin}, 16'h0000);
    step(1, 0, 17, 0, 8'h00);
    chk("R1 register after reset", last_rd, 16'h0000);

    // R9 only the high byte is writable
    step(0, 1, 17, 16'hA5FF, 8'h00);
    step(1, 0, 17, 0, 8'h00);
    chk("R9 low byte ignored", last_rd, 16'hA500);
    step(0, 1, 3, 16'hFFFF, 8'h00);
    step(1, 0, 17, 0, 8'h00);
    chk("R9 other address ignored", last_rd, 16'hA500);

    // R8 polling with enables cleared
    step(0, 1, 17, 16'h0000, 8'h00);
    step(0, 0, 17, 0, 8'h80);
    step(0, 0, 17, 0, 8'h00);
    chk("R8 pin inactive", {15'b0, irq_pin}, 16'h0000);
    step(1, 0, 17, 0, 8'h00);
    chk("R2 jabber at bit 7", last_rd, 16'h0080);
    step(1, 0, 17, 0, 8'h00);
    chk("R3 cleared by read", last_rd, 16'h0000);

    // R3 other addresses read 0 and do not clear
    step(0, 0, 17, 0, 8'h01);
    step(1, 0, 16, 0, 8'h00);
    chk("R3 other address reads 0", last_rd, 16'h0000);
    step(1, 0, 17, 0, 8'h00);
    chk("R2 an-done at bit 0 kept", last_rd, 16'h0001);

    // R5 receive error edge
    repeat (3) step(0, 0, 17, 0, 8'h40);
    step(1, 0, 17, 0, 8'h40);
    chk("R5 rise sets bit 6", last_rd, 16'h0040);
    step(0, 0, 17, 0, 8'h40);
    step(1, 0, 17, 0, 8'h40);
    chk("R5 held high sets once", last_rd, 16'h0000);
    step(0, 0, 17, 0, 8'h00);

    // R6 link transitions
    step(0, 0, 17, 0, 8'h04);
    step(0, 0, 17, 0, 8'h04);
    step(1, 0, 17, 0, 8'h04);
    chk("R6 link up ignored", last_rd, 16'h0000);
    step(0, 0, 17, 0, 8'h00);
    step(1, 0, 17, 0, 8'h00);
    chk("R6 link drop sets bit 2", last_rd, 16'h0004);

    // R4 event coinciding with the clearing read
    step(0, 0, 17, 0, 8'h20);
    step(1, 0, 17, 0, 8'h20);
    chk("R4 read sees page bit", last_rd, 16'h0020);
    step(1, 0, 17, 0, 8'h00);
    chk("R4 page bit survives", last_rd, 16'h0020);

    // R7 timing and polarity
    step(0, 1, 17, 16'h0800, 8'h00);
    chk("R7 idle before event", {15'b0, irq_pin}, 16'h0000);
    step(0, 0, 17, 0, 8'h08);
    chk("R7 active cycle after event", {15'b0, irq_pin}, 16'h0001);
    pol = 1'b0;
    #1;
    chk("R7 active low", {15'b0, irq_pin}, 16'h0000);
    step(1, 0, 17, 0, 8'h00);
    chk("R7 inactive after read", {15'b0, irq_pin}, 16'h0001);
    pol = 1'b1;

    // R10 reset with idle inputs, then link comes up
    do_reset();
    step(0, 0, 17, 0, 8'h04);
    step(1, 0, 17, 0, 8'h04);
    chk("R10 no spurious event", last_rd, 16'h0000);

    // Constrained random phase against the model
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] ev;
      logic       rd, wr;
      logic [4:0] a;
      ev    = 8'($urandom & $urandom & $urandom);
      ev[2] = (($urandom % 16) == 0) ? !m_link : m_link;
      rd    = ($urandom % 4) == 0;
      wr    = ($urandom % 8) == 0;
      a     = (($urandom % 4) == 0) ? 5'($urandom) : 5'd17;
      if (($urandom % 64) == 0) pol = !pol;
      step(rd, wr, a, 16'($urandom), ev);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule